// File: doc/BRIEF.md
# Two-Phase Linear CCD Line Timing Generator

This block produces every digital gate and clock waveform needed to read one line from a two-phase linear CCD sensor. It runs from a single master clock and repeats lines for as long as the enable input is high. A line has two parts. First comes a charge-move handshake. In it, the horizontal clocks are frozen, the transfer gate opens, the photo gate pulses inside the transfer gate window, and then the gates close in reverse order. After that comes a readout, which shifts out a fixed number of pixels with complementary phase clocks and a reset-gate pulse for each pixel.

Every sub-phase length is counted in master-clock cycles and taken from configuration inputs. These inputs are captured at the start of each line and raised to safe floors when they are too small. Downstream logic gets two strobes: a line-start strobe, and a sample strobe for each pixel that it uses to time the digitizer against the charge arriving at the output node. The line holds dummy and reference pixels around N_ACTIVE imaging pixels: 27 fixed extras in total (3 isolation, 10 + 10 shielded, 2 + 2 transition), plus a configurable overclock count.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is high, the outputs are ph1_o=1, ph2_o=0, and xfer_gate_o, photo_gate_o, reset_gate_o, sample_o and line_start_o are all 0. This holds even if reset arrives in the middle of a line.
- R2: From the line_start_o cycle until xfer_gate_o has fallen, the horizontal clocks stay parked with ph1_o=1 and ph2_o=0. xfer_gate_o rises exactly PARK_CYC cycles after the line_start_o cycle.
- R3: photo_gate_o rises exactly LEAD cycles after xfer_gate_o rises, and stays high for exactly PG cycles. It is high only while xfer_gate_o is high.
- R4: photo_gate_o falls first. xfer_gate_o falls exactly TAIL cycles later, so it is high for LEAD+PG+TAIL cycles.
- R5: Readout starts in the cycle after xfer_gate_o falls. Each pixel holds ph1_o high for HALF cycles and then low for HALF cycles, and ph2_o is always the inverse of ph1_o.
- R6: reset_gate_o is high for the first RG cycles of each pixel's ph1_o-high interval. RG is clamped to [1, HALF-1], so the reset gate is always low at least one cycle before ph1_o falls.
- R7: sample_o is a one-cycle pulse, SD cycles after the first cycle in which ph1_o is low. SD is clamped to [1, HALF-1].
- R8: Each line contains exactly 27 + N_ACTIVE + cfg_ovr pixels, counted as falling edges of ph1_o.
- R9: line_start_o is a one-cycle pulse at the first cycle of a line. The configuration inputs are captured for that line at that point. While en is high, the next line starts right after the last pixel. If en is low at the last pixel, the block idles parked with no further line_start_o.
- R10: Configured values below their floors are raised to the floor: HALF to at least 2, PG to at least 10, LEAD and TAIL to at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run lines continuously while high |
| cfg_half | input | CW | Half pixel period in cycles |
| cfg_rg | input | CW | Reset-gate high cycles per pixel |
| cfg_sdly | input | CW | Sample strobe delay after phase-1 fall |
| cfg_lead | input | CW | Transfer-gate-to-photo-gate lead cycles |
| cfg_pg | input | CW | Photo gate high cycles |
| cfg_tail | input | CW | Photo-gate-fall to transfer-gate-fall cycles |
| cfg_ovr | input | CW | Extra overclock pixels per line |
| ph1_o | output | 1 | Horizontal phase 1 clock |
| ph2_o | output | 1 | Horizontal phase 2 clock |
| xfer_gate_o | output | 1 | Transfer gate |
| photo_gate_o | output | 1 | Photo gate |
| reset_gate_o | output | 1 | Output-node reset gate |
| sample_o | output | 1 | Per-pixel sample strobe |
| line_start_o | output | 1 | Line start strobe |

## Verification
Two events can land in the same cycle at the line boundary. The last pixel's low half ends, the next line's configuration is captured, and its line-start strobe is raised. When SD is clamped to HALF-1, the sample strobe of the final pixel also sits in the final cycle of that line. The bench provokes this by running lines back to back, changing the configuration inputs during each line and using a vector whose sample delay clamps to the top of its window. It then compares every output cycle by cycle against a waveform computed from the requirements. The next line must start in exactly the expected cycle and must follow the new vector, and the last pixel's strobe must still appear.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_LEAD,
    ST_PG,
    ST_TAIL,
    ST_READ
  } lt_state_e;

  localparam int unsigned FIXED_PIX = 27;

endpackage

// File: rtl/ccd_lt_cfg.sv
module ccd_lt_cfg #(
  parameter int CW       = 8,
  parameter int MIN_HALF = 2,
  parameter int MIN_PG   = 10,
  parameter int MIN_LEAD = 1,
  parameter int MIN_TAIL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_rg,
  input  logic [CW-1:0] cfg_sdly,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_pg,
  input  logic [CW-1:0] cfg_tail,
  input  logic [CW-1:0] cfg_ovr,
  output logic [CW-1:0] half_q,
  output logic [CW-1:0] rg_q,
  output logic [CW-1:0] sd_q,
  output logic [CW-1:0] lead_q,
  output logic [CW-1:0] pg_q,
  output logic [CW-1:0] tail_q,
  output logic [CW-1:0] ovr_q
);

  localparam logic [CW-1:0] F_HALF = CW'(MIN_HALF);
  localparam logic [CW-1:0] F_PG   = CW'(MIN_PG);
  localparam logic [CW-1:0] F_LEAD = CW'(MIN_LEAD);
  localparam logic [CW-1:0] F_TAIL = CW'(MIN_TAIL);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] half_c, hmax_c, rg_c, sd_c;

  // floors first, then the per-pixel windows that depend on the half period
  always_comb begin
    half_c = (cfg_half < F_HALF) ? F_HALF : cfg_half;
    hmax_c = half_c - ONE;
    if (cfg_rg < ONE)         rg_c = ONE;
    else if (cfg_rg > hmax_c) rg_c = hmax_c;
    else                      rg_c = cfg_rg;
    if (cfg_sdly < ONE)         sd_c = ONE;
    else if (cfg_sdly > hmax_c) sd_c = hmax_c;
    else                        sd_c = cfg_sdly;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= F_HALF;
      rg_q   <= ONE;
      sd_q   <= ONE;
      lead_q <= F_LEAD;
      pg_q   <= F_PG;
      tail_q <= F_TAIL;
      ovr_q  <= '0;
    end else if (load) begin
      half_q <= half_c;
      rg_q   <= rg_c;
      sd_q   <= sd_c;
      lead_q <= (cfg_lead < F_LEAD) ? F_LEAD : cfg_lead;
      pg_q   <= (cfg_pg < F_PG) ? F_PG : cfg_pg;
      tail_q <= (cfg_tail < F_TAIL) ? F_TAIL : cfg_tail;
      ovr_q  <= cfg_ovr;
    end
  end

  assert_half_floor_R10: assert property (@(posedge clk) disable iff (rst)
    half_q >= F_HALF && pg_q >= F_PG && lead_q >= F_LEAD && tail_q >= F_TAIL)
    else $error("duration below floor");

  assert_rg_window_R6: assert property (@(posedge clk) disable iff (rst)
    rg_q >= ONE && rg_q < half_q)
    else $error("reset gate width outside window");

  assert_sd_window_R7: assert property (@(posedge clk) disable iff (rst)
    sd_q >= ONE && sd_q < half_q)
    else $error("sample delay outside window");

endmodule

// File: rtl/ccd_lt_pix.sv
module ccd_lt_pix #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] half,
  input  logic [CW-1:0] rgl,
  input  logic [CW-1:0] sd,
  output logic          h1_n,
  output logic          rg_n,
  output logic          smp_n,
  output logic          pix_end
);

  localparam int PHW = CW + 1;

  logic [PHW-1:0] ph;
  logic [PHW-1:0] hx, per_last, smp_at;

  assign hx       = {1'b0, half};
  assign per_last = (hx << 1) - PHW'(1);
  assign smp_at   = hx + {1'b0, sd};

  assign pix_end = run && (ph == per_last);
  assign h1_n    = !run || (ph < hx);
  assign rg_n    = run && (ph < {1'b0, rgl});
  assign smp_n   = run && (ph == smp_at);

  always_ff @(posedge clk) begin
    if (rst || !run || pix_end) ph <= '0;
    else                        ph <= ph + PHW'(1);
  end

  assert_ph_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> ph <= per_last)
    else $error("pixel phase counter overran its period");

endmodule

// File: rtl/ccd_lt_seq.sv
module ccd_lt_seq
  import ccd_lt_pkg::*;
#(
  parameter int CW       = 8,
  parameter int N_ACTIVE = 512,
  parameter int PARK_CYC = 2,
  parameter int PW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] lead,
  input  logic [CW-1:0] pg,
  input  logic [CW-1:0] tail,
  input  logic [CW-1:0] ovr,
  input  logic          pix_end,
  output lt_state_e     state,
  output logic          load,
  output logic          ls_n
);

  localparam logic [CW-1:0] PARK_LAST = CW'(PARK_CYC - 1);
  localparam logic [PW-1:0] BASE_PIX  = PW'(FIXED_PIX + N_ACTIVE);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pix;
  logic [PW-1:0] npix;
  logic          last_pix;

  assign npix     = BASE_PIX + PW'(ovr);
  assign last_pix = (pix == npix - PW'(1));
  assign load     = (state == ST_IDLE && en) ||
                    (state == ST_READ && pix_end && last_pix && en);
  assign ls_n     = (state == ST_PARK) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pix   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (en) state <= ST_PARK;
        end
        ST_PARK: begin
          if (cnt == PARK_LAST) begin state <= ST_LEAD; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        end
        ST_LEAD: begin
          if (cnt == lead - CW'(1)) begin state <= ST_PG; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        end
        ST_PG: begin
          if (cnt == pg - CW'(1)) begin state <= ST_TAIL; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        end
        ST_TAIL: begin
          if (cnt == tail - CW'(1)) begin
            state <= ST_READ;
            cnt   <= '0;
            pix   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        ST_READ: begin
          if (pix_end) begin
            if (last_pix) begin
              state <= en ? ST_PARK : ST_IDLE;
              cnt   <= '0;
              pix   <= '0;
            end else pix <= pix + PW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_pix_bound_R8: assert property (@(posedge clk) disable iff (rst)
    state == ST_READ |-> pix < npix)
    else $error("pixel index beyond line length");

  assert_load_at_start_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> state == ST_PARK && cnt == '0)
    else $error("configuration captured outside line start");

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_lt_pkg::*;
#(
  parameter int CW       = 8,
  parameter int N_ACTIVE = 512,
  parameter int PARK_CYC = 2,
  parameter int MIN_HALF = 2,
  parameter int MIN_PG   = 10,
  parameter int MIN_LEAD = 1,
  parameter int MIN_TAIL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_rg,
  input  logic [CW-1:0] cfg_sdly,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_pg,
  input  logic [CW-1:0] cfg_tail,
  input  logic [CW-1:0] cfg_ovr,
  output logic          ph1_o,
  output logic          ph2_o,
  output logic          xfer_gate_o,
  output logic          photo_gate_o,
  output logic          reset_gate_o,
  output logic          sample_o,
  output logic          line_start_o
);

  localparam int PW = $clog2(FIXED_PIX + N_ACTIVE + (1 << CW)) + 1;

  logic [CW-1:0] half_q, rg_q, sd_q, lead_q, pg_q, tail_q, ovr_q;
  lt_state_e     state;
  logic          load, ls_n, h1_n, rg_n, smp_n, pix_end;

  ccd_lt_cfg #(
    .CW(CW), .MIN_HALF(MIN_HALF), .MIN_PG(MIN_PG),
    .MIN_LEAD(MIN_LEAD), .MIN_TAIL(MIN_TAIL)
  ) cfg_i (
    .clk(clk), .rst(rst), .load(load),
    .cfg_half(cfg_half), .cfg_rg(cfg_rg), .cfg_sdly(cfg_sdly),
    .cfg_lead(cfg_lead), .cfg_pg(cfg_pg), .cfg_tail(cfg_tail), .cfg_ovr(cfg_ovr),
    .half_q(half_q), .rg_q(rg_q), .sd_q(sd_q),
    .lead_q(lead_q), .pg_q(pg_q), .tail_q(tail_q), .ovr_q(ovr_q)
  );

  ccd_lt_seq #(
    .CW(CW), .N_ACTIVE(N_ACTIVE), .PARK_CYC(PARK_CYC), .PW(PW)
  ) seq_i (
    .clk(clk), .rst(rst), .en(en),
    .lead(lead_q), .pg(pg_q), .tail(tail_q), .ovr(ovr_q),
    .pix_end(pix_end), .state(state), .load(load), .ls_n(ls_n)
  );

  ccd_lt_pix #(.CW(CW)) pix_i (
    .clk(clk), .rst(rst), .run(state == ST_READ),
    .half(half_q), .rgl(rg_q), .sd(sd_q),
    .h1_n(h1_n), .rg_n(rg_n), .smp_n(smp_n), .pix_end(pix_end)
  );

  // one register stage on every pin keeps all edges aligned and glitch free
  always_ff @(posedge clk) begin
    if (rst) begin
      ph1_o        <= 1'b1;
      ph2_o        <= 1'b0;
      xfer_gate_o  <= 1'b0;
      photo_gate_o <= 1'b0;
      reset_gate_o <= 1'b0;
      sample_o     <= 1'b0;
      line_start_o <= 1'b0;
    end else begin
      ph1_o        <= h1_n;
      ph2_o        <= !h1_n;
      xfer_gate_o  <= state inside {ST_LEAD, ST_PG, ST_TAIL};
      photo_gate_o <= (state == ST_PG);
      reset_gate_o <= rg_n;
      sample_o     <= smp_n;
      line_start_o <= ls_n;
    end
  end

  assert_xfer_parked_R2: assert property (@(posedge clk) disable iff (rst)
    xfer_gate_o |-> ph1_o && !ph2_o)
    else $error("horizontal clocks not parked during transfer");

  assert_photo_inside_R3: assert property (@(posedge clk) disable iff (rst)
    photo_gate_o |-> xfer_gate_o)
    else $error("photo gate high without transfer gate");

  assert_photo_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(photo_gate_o) |-> $past(xfer_gate_o))
    else $error("photo gate rose before transfer gate settled");

  assert_xfer_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_gate_o) |-> !$past(photo_gate_o))
    else $error("transfer gate fell with photo gate still high");

  assert_half_min_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ph1_o) |-> $past(ph1_o, 2))
    else $error("phase 1 high shorter than two cycles");

  assert_rg_in_high_R6: assert property (@(posedge clk) disable iff (rst)
    reset_gate_o |-> ph1_o)
    else $error("reset gate high while phase 1 low");

  assert_rg_before_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ph1_o) |-> !$past(reset_gate_o))
    else $error("reset gate not low before phase 1 fall");

  assert_sample_low_R7: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> !ph1_o && !xfer_gate_o)
    else $error("sample strobe outside phase-1 low interval");

  assert_start_parked_R9: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> ph1_o && !xfer_gate_o && !sample_o)
    else $error("line start while not parked");

endmodule

// File: tb/ccd_line_timer_tb.sv
module ccd_line_timer_tb_top;

  localparam int CW   = 8;
  localparam int NA   = 4;
  localparam int PARK = 2;
  localparam int NV   = 6;

  typedef struct packed {
    logic [7:0] h, rg, sd, ld, pg, tl, ov;
    logic [7:0] eh, erg, esd, eld, epg, etl;
  } vec_t;

  // inputs, then expected values after clamping
  localparam vec_t VEC [NV] = '{
    '{8'd3, 8'd1, 8'd1, 8'd2, 8'd12, 8'd2, 8'd0, 8'd3, 8'd1, 8'd1, 8'd2, 8'd12, 8'd2},
    '{8'd5, 8'd3, 8'd4, 8'd1, 8'd10, 8'd1, 8'd3, 8'd5, 8'd3, 8'd4, 8'd1, 8'd10, 8'd1},
    '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0, 8'd2, 8'd1, 8'd1, 8'd1, 8'd10, 8'd1},
    '{8'd4, 8'd9, 8'd9, 8'd3, 8'd5,  8'd4, 8'd1, 8'd4, 8'd3, 8'd3, 8'd3, 8'd10, 8'd4},
    '{8'd2, 8'd1, 8'd1, 8'd1, 8'd11, 8'd1, 8'd2, 8'd2, 8'd1, 8'd1, 8'd1, 8'd11, 8'd1},
    '{8'd6, 8'd5, 8'd2, 8'd1, 8'd20, 8'd3, 8'd0, 8'd6, 8'd5, 8'd2, 8'd1, 8'd20, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CW-1:0] cfg_half, cfg_rg, cfg_sdly, cfg_lead, cfg_pg, cfg_tail, cfg_ovr;
  logic ph1_o, ph2_o, xfer_gate_o, photo_gate_o, reset_gate_o, sample_o, line_start_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ccd_line_timer #(.CW(CW), .N_ACTIVE(NA), .PARK_CYC(PARK)) dut_i (
    .clk(clk), .rst(rst), .en(en),
    .cfg_half(cfg_half), .cfg_rg(cfg_rg), .cfg_sdly(cfg_sdly),
    .cfg_lead(cfg_lead), .cfg_pg(cfg_pg), .cfg_tail(cfg_tail), .cfg_ovr(cfg_ovr),
    .ph1_o(ph1_o), .ph2_o(ph2_o), .xfer_gate_o(xfer_gate_o),
    .photo_gate_o(photo_gate_o), .reset_gate_o(reset_gate_o),
    .sample_o(sample_o), .line_start_o(line_start_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic drive(input int k);
    cfg_half = VEC[k].h;  cfg_rg   = VEC[k].rg; cfg_sdly = VEC[k].sd;
    cfg_lead = VEC[k].ld; cfg_pg   = VEC[k].pg; cfg_tail = VEC[k].tl;
    cfg_ovr  = VEC[k].ov;
  endtask

  task automatic chk_reset_outputs(input string tag);
    chk({tag, " ph1"}, int'(ph1_o), 1);
    chk({tag, " ph2"}, int'(ph2_o), 0);
    chk({tag, " gates/rg"}, int'({xfer_gate_o, photo_gate_o, reset_gate_o}), 0);
    chk({tag, " strobes"}, int'({sample_o, line_start_o}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    drive(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_outputs("R1 reset");
    rst = 1'b0;
    en  = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int eh, erg, esd, eld, epg, etl, npix, r0, len;
      int m_park, m_tg, m_pg, m_h, m_rg, m_smp, m_ls, falls;
      logic prev;
      while (!line_start_o) @(negedge clk);
      // next line's settings are presented while this one runs
      if (i + 1 < NV) drive(i + 1);
      else en = 1'b0;
      eh = VEC[i].eh; erg = VEC[i].erg; esd = VEC[i].esd;
      eld = VEC[i].eld; epg = VEC[i].epg; etl = VEC[i].etl;
      npix = 27 + NA + int'(VEC[i].ov);
      r0 = PARK + eld + epg + etl;
      len = r0 + npix * 2 * eh;
      m_park = 0; m_tg = 0; m_pg = 0; m_h = 0; m_rg = 0; m_smp = 0; m_ls = 0;
      falls = 0; prev = 1'b1;
      for (int t = 0; t < len; t++) begin
        logic e_h1, e_rg, e_smp;
        if (t < r0) begin
          e_h1 = 1'b1; e_rg = 1'b0; e_smp = 1'b0;
          if (ph1_o !== 1'b1 || ph2_o !== 1'b0) m_park++;
        end else begin
          int ph;
          ph = (t - r0) % (2 * eh);
          e_h1 = (ph < eh); e_rg = (ph < erg); e_smp = (ph == eh + esd);
          if (ph1_o !== e_h1 || ph2_o !== !e_h1) m_h++;
        end
        if (xfer_gate_o !== (t >= PARK && t < r0)) m_tg++;
        if (photo_gate_o !== (t >= PARK + eld && t < PARK + eld + epg)) m_pg++;
        if (reset_gate_o !== e_rg) m_rg++;
        if (sample_o !== e_smp) m_smp++;
        if (line_start_o !== (t == 0)) m_ls++;
        if (prev && !ph1_o) falls++;
        prev = ph1_o;
        @(negedge clk);
      end
      chk($sformatf("R2 parked clocks, vector %0d (mismatch cycles)", i), m_park, 0);
      chk($sformatf("R3 photo gate timing, vector %0d", i), m_pg, 0);
      chk($sformatf("R4 transfer gate timing, vector %0d", i), m_tg, 0);
      chk($sformatf("R5 phase clocks, vector %0d", i), m_h, 0);
      chk($sformatf("R6 reset gate, vector %0d", i), m_rg, 0);
      chk($sformatf("R7 sample strobe, vector %0d", i), m_smp, 0);
      chk($sformatf("R8 pixel count, vector %0d", i), falls, npix);
      chk($sformatf("R9 single start strobe, vector %0d", i), m_ls, 0);
      chk($sformatf("R9 next line start, vector %0d", i), int'(line_start_o), (i + 1 < NV) ? 1 : 0);
    end

    // R9: en dropped during the last line, so the block must idle parked
    begin
      int bad;
      bad = 0;
      for (int t = 0; t < 40; t++) begin
        if (ph1_o !== 1'b1 || ph2_o !== 1'b0 || xfer_gate_o || line_start_o || sample_o) bad++;
        @(negedge clk);
      end
      chk("R9 idle after en low (bad cycles)", bad, 0);
    end

    // R1: reset in the middle of the transfer handshake
    drive(0);
    en = 1'b1;
    while (!line_start_o) @(negedge clk);
    repeat (PARK + 3) @(negedge clk);
    chk("R1 precondition photo gate high", int'(photo_gate_o), 1);
    rst = 1'b1;
    @(negedge clk);
    chk_reset_outputs("R1 mid-line reset");
    en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule